// File: doc/BRIEF.md
# Trap and Interrupt Arbiter

This block sits at the last stage of an integer pipeline and decides, once per cycle, whether control leaves the normal instruction stream. Exception requests raised by the retiring instruction arrive as a vector of request lines. A 4-bit external interrupt level arrives alongside them. The block picks at most one winner. On a trap it clears the trap-enable flag, moves the register window pointer down by one and issues a fetch redirect to a vector formed from the trap base. It then writes the interrupted program counter pair into two local registers of the new window through the register file's single write port.

The block owns the architectural state that controls trap entry: the trap-enable flag, the 4-bit processor interrupt level, the window pointer and the trap base. The pipeline loads these through a control write when it executes the corresponding instructions. A synchronous request that arrives while traps are disabled cannot be serviced. The block then locks into an error mode, where it does nothing until an external reset. Reset itself is reported as a redirect to address zero.

Top module: `trap_arbiter`

## Requirements
- R1: While reset is held, `et` is 0, `pil` is 0, `cwp` is 0, `err_mode` is 0, and `redir_valid` is 1 with `redir_addr` 0. In the first cycle after reset is released, `redir_valid` is 0.
- R2: When several bits of `sync_req` are set, the lowest-numbered bit wins. Request bit i reports trap type i+1.
- R3: A pending synchronous request always wins over a pending interrupt in the same cycle.
- R4: A nonzero `irq_level` below 15 is accepted only when it is strictly greater than `pil`. An accepted level n reports trap type 0x10+n. A level of 0 is never a request.
- R5: Level 15 is accepted whatever the value of `pil`, provided traps are enabled.
- R6: While `et` is 0, every interrupt level, including 15, is ignored, and no trap is reported.
- R7: A synchronous request while `et` is 0 sets `err_mode`. After that, no trap, redirect, control write or register-file write takes effect until reset.
- R8: Taking a trap clears `et` and decrements `cwp` modulo NWIN, with 0 wrapping to NWIN-1. `trap_taken` pulses for exactly one cycle.
- R9: With each trap, `redir_valid` is 1 and `redir_addr` is {trap base, 8-bit trap type, 4'b0000}.
- R10: The cycle after a trap, `rf_we` writes the trap-time `pc_in` to local slot 1 of the new window. The following cycle, it writes the trap-time `npc_in` to slot 2.
- R11: `ctl_wr` loads `et`, `pil`, `cwp` and the trap base from the `ctl_*` inputs. A control write is ignored in a cycle that takes a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | NSYNC | Exception requests of the retiring instruction, bit 0 highest priority |
| irq_level | input | 4 | External interrupt level, 0 means none |
| pc_in | input | AW | Program counter of the retiring instruction |
| npc_in | input | AW | Next program counter |
| ctl_wr | input | 1 | Load control state from the ctl_* inputs |
| ctl_et | input | 1 | New trap-enable value |
| ctl_pil | input | 4 | New processor interrupt level |
| ctl_cwp | input | CWPW | New window pointer |
| ctl_tba | input | AW-12 | New trap base |
| trap_taken | output | 1 | One-cycle pulse per trap |
| trap_type | output | 8 | Type of the last trap taken |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_addr | output | AW | Fetch redirect address |
| et | output | 1 | Trap-enable flag |
| pil | output | 4 | Processor interrupt level |
| cwp | output | CWPW | Current window pointer |
| err_mode | output | 1 | Error-mode lock |
| rf_we | output | 1 | Register-file write strobe for the counter save |
| rf_win | output | CWPW | Window written |
| rf_reg | output | 3 | Local slot written |
| rf_data | output | AW | Data written |

## Verification
Some properties are checked on every cycle by the assertions: each trap leaves `et` clear and the window one lower, the redirect carries the reported type in its middle field, and an accepted maskable level exceeds the prior `pil`. They also check that the two-step save starts on the trap cycle and that error mode, once set, stays set and silent. Other behaviours can only be shown by the bench's scenarios: which request wins when several compete, that equal or lower levels and disabled traps produce nothing, that a control write colliding with a trap is dropped, and that a reset clears the lock.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam int TT_W  = 8;
  localparam int LVL_W = 4;
  localparam int SLOT_W = 3;
  localparam logic [TT_W-1:0]   IRQ_TT_BASE = 8'h10;
  localparam logic [LVL_W-1:0]  NMI_LVL     = 4'hF;
  localparam logic [SLOT_W-1:0] PC_SLOT     = 3'd1;
  localparam logic [SLOT_W-1:0] NPC_SLOT    = 3'd2;
endpackage

// File: rtl/trap_sync_prio.sv
module trap_sync_prio
  import trap_arb_pkg::*;
#(
  parameter int NSYNC = 8,
  localparam int IW = $clog2(NSYNC)
) (
  input  logic [NSYNC-1:0] req,
  output logic             any,
  output logic [TT_W-1:0]  tt
);
  logic [IW-1:0] idx;

  // scan from the least urgent line down so the lowest index is left last
  always_comb begin
    idx = '0;
    for (int i = NSYNC - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IW-1:0];
    end
  end

  assign any = |req;
  assign tt  = TT_W'(idx) + TT_W'(1);
endmodule

// File: rtl/trap_irq_gate.sv
module trap_irq_gate
  import trap_arb_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] cur_pil,
  input  logic             enabled,
  output logic             accept,
  output logic [TT_W-1:0]  tt
);
  logic pending, unmasked;

  assign pending  = (level != '0);
  assign unmasked = (level == NMI_LVL) || (level > cur_pil);
  assign accept   = enabled && pending && unmasked;
  assign tt       = IRQ_TT_BASE + TT_W'(level);
endmodule

// File: rtl/trap_pc_saver.sv
module trap_pc_saver
  import trap_arb_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CWPW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              start,
  input  logic [CWPW-1:0]   win_in,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     npc,
  output logic              we,
  output logic [CWPW-1:0]   win,
  output logic [SLOT_W-1:0] slot,
  output logic [AW-1:0]     data
);
  logic          second;
  logic [AW-1:0] npc_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      we       <= 1'b0;
      second   <= 1'b0;
      win      <= '0;
      slot     <= '0;
      data     <= '0;
      npc_hold <= '0;
    end else if (halt) begin
      we     <= 1'b0;
      second <= 1'b0;
    end else if (start) begin
      we       <= 1'b1;
      win      <= win_in;
      slot     <= PC_SLOT;
      data     <= pc;
      npc_hold <= npc;
      second   <= 1'b1;
    end else if (second) begin
      we     <= 1'b1;
      slot   <= NPC_SLOT;
      data   <= npc_hold;
      second <= 1'b0;
    end else begin
      we <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_arb_pkg::*;
#(
  parameter int NSYNC = 8,
  parameter int NWIN  = 8,
  parameter int AW    = 32,
  localparam int CWPW = $clog2(NWIN),
  localparam int TBAW = AW - 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSYNC-1:0]  sync_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [AW-1:0]     pc_in,
  input  logic [AW-1:0]     npc_in,
  input  logic              ctl_wr,
  input  logic              ctl_et,
  input  logic [LVL_W-1:0]  ctl_pil,
  input  logic [CWPW-1:0]   ctl_cwp,
  input  logic [TBAW-1:0]   ctl_tba,
  output logic              trap_taken,
  output logic [TT_W-1:0]   trap_type,
  output logic              redir_valid,
  output logic [AW-1:0]     redir_addr,
  output logic              et,
  output logic [LVL_W-1:0]  pil,
  output logic [CWPW-1:0]   cwp,
  output logic              err_mode,
  output logic              rf_we,
  output logic [CWPW-1:0]   rf_win,
  output logic [SLOT_W-1:0] rf_reg,
  output logic [AW-1:0]     rf_data
);
  localparam logic [CWPW-1:0] WTOP = CWPW'(NWIN - 1);

  logic [TBAW-1:0] tba;
  logic            sync_any, irq_ok, take, fault;
  logic [TT_W-1:0] sync_tt, irq_tt, win_tt;
  logic [CWPW-1:0] cwp_dn;

  trap_sync_prio #(.NSYNC(NSYNC)) u_prio (
    .req (sync_req),
    .any (sync_any),
    .tt  (sync_tt)
  );

  trap_irq_gate u_gate (
    .level   (irq_level),
    .cur_pil (pil),
    .enabled (et),
    .accept  (irq_ok),
    .tt      (irq_tt)
  );

  assign take   = et && (sync_any || irq_ok);
  assign fault  = sync_any && !et;
  assign win_tt = sync_any ? sync_tt : irq_tt;
  assign cwp_dn = (cwp == '0) ? WTOP : cwp - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      et          <= 1'b0;
      pil         <= '0;
      cwp         <= '0;
      tba         <= '0;
      err_mode    <= 1'b0;
      trap_taken  <= 1'b0;
      trap_type   <= '0;
      redir_valid <= 1'b1;
      redir_addr  <= '0;
    end else if (err_mode) begin
      trap_taken  <= 1'b0;
      redir_valid <= 1'b0;
    end else begin
      trap_taken  <= take;
      redir_valid <= take;
      if (take) begin
        trap_type  <= win_tt;
        redir_addr <= {tba, win_tt, 4'b0000};
        et         <= 1'b0;
        cwp        <= cwp_dn;
      end else if (fault) begin
        err_mode <= 1'b1;
      end else if (ctl_wr) begin
        et  <= ctl_et;
        pil <= ctl_pil;
        cwp <= ctl_cwp;
        tba <= ctl_tba;
      end
    end
  end

  trap_pc_saver #(.AW(AW), .CWPW(CWPW)) u_saver (
    .clk    (clk),
    .rst    (rst),
    .halt   (err_mode),
    .start  (take && !err_mode),
    .win_in (cwp_dn),
    .pc     (pc_in),
    .npc    (npc_in),
    .we     (rf_we),
    .win    (rf_win),
    .slot   (rf_reg),
    .data   (rf_data)
  );

  // R8
  et_clear_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> !et);

  // R8
  cwp_step_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> cwp == (($past(cwp) == '0) ? WTOP : $past(cwp) - 1'b1));

  // R6
  irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_taken && trap_type >= IRQ_TT_BASE) |-> $past(et));

  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_taken && trap_type > IRQ_TT_BASE && trap_type < 8'h1F)
      |-> trap_type[3:0] > $past(pil));

  // R9
  vec_form_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> redir_valid && redir_addr[11:4] == trap_type
                   && redir_addr[3:0] == 4'b0000);

  // R10
  save_first_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> rf_we && rf_reg == PC_SLOT && rf_win == cwp);

  // R10
  save_second_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken |=> rf_we && rf_reg == NPC_SLOT && $stable(rf_win));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_mode |=> err_mode && !trap_taken && !redir_valid && !rf_we);
endmodule

// File: tb/trap_arbiter_bench.sv
`timescale 1ns/1ps
module trap_arbiter_bench;
  localparam int NSYNC = 8;
  localparam int NWIN  = 8;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSYNC-1:0] sync_req = '0;
  logic [3:0]  irq_level = '0;
  logic [31:0] pc_in = '0, npc_in = '0;
  logic        ctl_wr = 1'b0, ctl_et = 1'b0;
  logic [3:0]  ctl_pil = '0;
  logic [2:0]  ctl_cwp = '0;
  logic [19:0] ctl_tba = '0;

  logic        trap_taken, redir_valid, et, err_mode, rf_we;
  logic [7:0]  trap_type;
  logic [31:0] redir_addr, rf_data;
  logic [3:0]  pil;
  logic [2:0]  cwp, rf_win, rf_reg;

  always #2.5 clk = ~clk;

  trap_arbiter #(.NSYNC(NSYNC), .NWIN(NWIN), .AW(AW)) u_trap_arbiter (
    .clk(clk), .rst(rst), .sync_req(sync_req), .irq_level(irq_level),
    .pc_in(pc_in), .npc_in(npc_in), .ctl_wr(ctl_wr), .ctl_et(ctl_et),
    .ctl_pil(ctl_pil), .ctl_cwp(ctl_cwp), .ctl_tba(ctl_tba),
    .trap_taken(trap_taken), .trap_type(trap_type), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .et(et), .pil(pil), .cwp(cwp), .err_mode(err_mode),
    .rf_we(rf_we), .rf_win(rf_win), .rf_reg(rf_reg), .rf_data(rf_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit started = 0, done = 0;

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_et, m_pil, m_cwp, m_tba, m_err, m_tk, m_tt, m_rv, m_we, m_ph, m_win, m_reg;
  logic [31:0] m_ra, m_data, m_hold;
  int s, ncwp;
  bit irq_ok, take;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_et = 0; m_pil = 0; m_cwp = 0; m_tba = 0; m_err = 0; m_tk = 0; m_tt = 0;
      m_rv = 1; m_ra = 0; m_we = 0; m_ph = 0; m_win = 0; m_reg = 0; m_data = 0; m_hold = 0;
    end else if (m_err != 0) begin
      m_tk = 0; m_rv = 0; m_we = 0; m_ph = 0;
    end else begin
      s = -1;
      for (int i = 0; i < NSYNC; i++) if (sync_req[i] && s < 0) s = i;
      irq_ok = (irq_level != 0) && (irq_level == 15 || int'(irq_level) > m_pil);
      take = (m_et != 0) && (s >= 0 || irq_ok);
      ncwp = (m_cwp + NWIN - 1) % NWIN;
      if (take) begin
        m_we = 1; m_win = ncwp; m_reg = 1; m_data = pc_in; m_hold = npc_in; m_ph = 1;
      end else if (m_ph != 0) begin
        m_we = 1; m_reg = 2; m_data = m_hold; m_ph = 0;
      end else m_we = 0;
      m_tk = take; m_rv = take;
      if (take) begin
        m_tt = (s >= 0) ? s + 1 : 16 + int'(irq_level);
        m_ra = 32'(m_tba) * 32'd4096 + 32'(m_tt) * 32'd16;
        m_et = 0; m_cwp = ncwp;
      end else if (s >= 0) begin
        m_err = 1;
      end else if (ctl_wr) begin
        m_et = ctl_et; m_pil = ctl_pil; m_cwp = ctl_cwp; m_tba = ctl_tba;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      cmp("R2 taken/type", {trap_taken, trap_type}, {1'(m_tk), 8'(m_tt)});
      cmp("R9 redirect", {redir_valid, redir_addr}, {1'(m_rv), m_ra});
      cmp("R8 et/cwp", {et, cwp}, {1'(m_et), 3'(m_cwp)});
      cmp("R11 pil", 64'(pil), 64'(m_pil));
      cmp("R7 err_mode", 64'(err_mode), 64'(m_err));
      cmp("R10 rf port", {rf_we, rf_win, rf_reg, rf_data}, {1'(m_we), 3'(m_win), 3'(m_reg), m_data});
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    sync_req = '0; irq_level = '0; ctl_wr = 1'b0;
  endtask

  task automatic ctl(input bit e, input int p, input int w, input int b);
    ctl_wr = 1; ctl_et = e; ctl_pil = 4'(p); ctl_cwp = 3'(w); ctl_tba = 20'(b);
    cyc(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; cyc(); cyc(); cyc();
    cmp("R1 reset redirect", {redir_valid, redir_addr}, {1'b1, 32'h0});
    cmp("R1 reset state", {et, pil, cwp, err_mode}, 0);
    rst = 0; cyc();
    cmp("R1 redirect drops", 64'(redir_valid), 0);

    ctl(1, 5, 3, 20'hABCDE);
    cmp("R11 control load", {et, pil, cwp}, {1'b1, 4'd5, 3'd3});

    irq_level = 5; cyc();
    cmp("R4 equal level ignored", 64'(trap_taken), 0);
    irq_level = 3; cyc();
    cmp("R4 lower level ignored", 64'(trap_taken), 0);
    irq_level = 0; cyc();
    cmp("R4 level zero", 64'(trap_taken), 0);

    irq_level = 6; pc_in = 32'h1000; npc_in = 32'h1004; cyc(); idle();
    cmp("R4 type", {trap_taken, trap_type}, {1'b1, 8'h16});
    cmp("R9 vector", 64'(redir_addr), 64'({20'hABCDE, 8'h16, 4'h0}));
    cmp("R8 entry", {et, cwp}, {1'b0, 3'd2});
    cmp("R10 first save", {rf_we, rf_win, rf_reg, rf_data}, {1'b1, 3'd2, 3'd1, 32'h1000});
    cyc();
    cmp("R8 pulse width", 64'(trap_taken), 0);
    cmp("R10 second save", {rf_we, rf_win, rf_reg, rf_data}, {1'b1, 3'd2, 3'd2, 32'h1004});
    cyc();
    cmp("R10 port idle", 64'(rf_we), 0);

    irq_level = 15; cyc(); cyc(); idle();
    cmp("R6 level 15 with traps off", 64'(trap_taken), 0);

    ctl(1, 15, 2, 20'h00010);
    irq_level = 14; cyc();
    cmp("R4 masked at pil 15", 64'(trap_taken), 0);
    irq_level = 15; cyc(); idle();
    cmp("R5 non-maskable", {trap_taken, trap_type, cwp}, {1'b1, 8'h1F, 3'd1});
    cyc(); cyc();

    ctl(1, 0, 0, 20'h00020);
    sync_req = 8'b0010_0100; irq_level = 15; cyc(); idle();
    cmp("R2 R3 lowest sync wins", {trap_taken, trap_type}, {1'b1, 8'h03});
    cmp("R8 window wrap", 64'(cwp), 64'(7));
    cyc(); cyc();

    ctl(1, 0, 4, 20'h00020);
    sync_req = 8'h80; ctl_wr = 1; ctl_et = 1; ctl_cwp = 3'd6; cyc(); idle();
    cmp("R11 control dropped on trap", {trap_taken, trap_type, et, cwp}, {1'b1, 8'h08, 1'b0, 3'd3});
    cyc(); cyc();

    sync_req = 8'h01; cyc(); idle();
    cmp("R7 error entry", {err_mode, trap_taken}, {1'b1, 1'b0});
    ctl(1, 0, 5, 20'h00030);
    cmp("R7 control frozen", {et, cwp}, {1'b0, 3'd3});
    irq_level = 9; cyc(); cyc(); idle();
    cmp("R7 quiet", {trap_taken, redir_valid, rf_we}, 0);
    sync_req = 8'h02; cyc(); idle();
    cmp("R7 sticky", 64'(err_mode), 1);
    rst = 1; cyc(); rst = 0; cyc();
    cmp("R1 R7 reset clears lock", {err_mode, et, cwp}, 0);

    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom % 64);
      sync_req  = (r < 5) ? NSYNC'(1 << ($urandom % NSYNC)) | NSYNC'($urandom % 4) : '0;
      irq_level = 4'($urandom);
      ctl_wr    = (r % 4 == 0);
      ctl_et    = 1'b1;
      ctl_pil   = 4'($urandom);
      ctl_cwp   = 3'($urandom);
      ctl_tba   = 20'($urandom);
      pc_in     = $urandom;
      npc_in    = $urandom;
      rst       = (k % 113 == 112);
      cyc();
    end
    idle(); rst = 0; cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule